// File: doc/BRIEF.md
# Gated multi-source frequency meter

This block measures the frequency of one of three free-running clocks (a prescaler output, an intermediate-frequency clock and a calibration oscillator) against a reference clock. Software picks a source and one of four gate lengths, then sets a start bit. The block opens a gate window that lasts an exact number of reference cycles and counts the rising edges of the selected clock during that window. The count saturates instead of wrapping. When the window closes, the block stores the count in the result register pair that belongs to that source and then clears the start bit.

Each counted clock is brought into the reference domain through a two-flop synchroniser and a rising-edge detector. A source must therefore run below half the reference rate. The frequency in kHz is the stored count divided by the gate length in milliseconds. Because a millisecond is `REF_KHZ` reference cycles, a bench can use a small `REF_KHZ` to shorten every window. The register port is a plain write strobe with an address and write data, and reads are combinational. Results are `CNT_W` bits wide, zero-extended to 16, and read as a low byte and a high byte.

Top module: `fcm_top`

## Requirements
- R1: After reset, every address (0 to 7) reads 0x00.
- R2: Writing address 0 with bit 0 = 1 starts a measurement. Bit 0 of address 0 reads 1 while the measurement runs and returns to 0 by itself once the result is stored. The source field (bits 6:4) and the gate field (bits 2:1) read back as written. Bits 7 and 3 read 0.
- R3: Gate code 0, 1, 2 and 3 gives a window of 4, 8, 32 and 64 ms, where 1 ms is `REF_KHZ` reference cycles. The start bit reads 1 for exactly ms*`REF_KHZ`+1 reference cycles, counted from the write edge.
- R4: Source codes 1 and 7 select the IF clock, 2 and 3 select the prescaler clock, and 4 and 5 select the calibration clock.
- R5: The stored count is the number of rising edges of the selected clock inside the window. For a clock with period p reference cycles and a window of G cycles, the count lies within one of G/p.
- R6: The count stops at 2^`CNT_W`-1 and does not wrap.
- R7: With source code 0 or 6, the measurement still runs its full window and then sets all three result pairs to 0.
- R8: A measurement with a used source code changes only that source's result pair. The other two pairs keep their values.
- R9: A write to address 0 while bit 0 reads 1 is ignored. Source, gate, start and the running window are unchanged.
- R10: Writes to addresses 1 to 7 have no effect. Address 1 always reads 0.
- R11: Address 2/3 holds the prescaler result, 4/5 the IF result and 6/7 the calibration result. The even address holds bits 7:0 and the odd address holds bits 15:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst | input | 1 | Synchronous active-high reset |
| pre_clk_i | input | 1 | Prescaler clock to be measured (asynchronous) |
| if_clk_i | input | 1 | IF clock to be measured (asynchronous) |
| cal_clk_i | input | 1 | Calibration oscillator to be measured (asynchronous) |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register address for read and write |
| wdata_i | input | 8 | Register write data |
| rdata_o | output | 8 | Register read data (combinational) |

## Verification
The hardest case to reach from the ports is saturation. It needs more than 2^`CNT_W` edges inside a single window. The bench therefore builds the block with a 12-bit count and a short millisecond. It then drives the prescaler input at half the reference rate with the 64 ms gate, so the 6400 edges overrun the 4095 limit, while the 32 ms gate on the same clock stays just below it. The lockout of control writes is also timed from the ports: a conflicting control write lands in the middle of a window, and the bench then checks the busy length and the fields read back.

// File: rtl/fcm_pkg.sv
package fcm_pkg;

    localparam int unsigned NUM_SRC = 3;
    localparam int unsigned RES_W   = 16;
    localparam logic [2:0]  ADDR_CTL = 3'd0;

    // Physical source index; SRC_NONE marks an unused selector code.
    typedef enum logic [1:0] {
        SRC_PRESC = 2'd0,
        SRC_IF    = 2'd1,
        SRC_CAL   = 2'd2,
        SRC_NONE  = 2'd3
    } src_e;

    typedef struct packed {
        logic [2:0] sel;
        logic [1:0] gate;
        logic       start;
    } ctl_t;

    function automatic src_e decode_src(input logic [2:0] code);
        src_e r;
        case (code)
            3'd1, 3'd7: r = SRC_IF;
            3'd2, 3'd3: r = SRC_PRESC;
            3'd4, 3'd5: r = SRC_CAL;
            default:    r = SRC_NONE;
        endcase
        return r;
    endfunction

    function automatic int unsigned gate_ms(input logic [1:0] code);
        int unsigned r;
        case (code)
            2'd0:    r = 4;
            2'd1:    r = 8;
            2'd2:    r = 32;
            default: r = 64;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/fcm_edge_sync.sv
module fcm_edge_sync #(
    parameter int unsigned N      = 3,
    parameter int unsigned STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] async_i,
    output logic [N-1:0] rise_o
);
    localparam int unsigned SH_W = STAGES + 1;

    for (genvar g = 0; g < N; g++) begin : g_ch
        logic [SH_W-1:0] sh_q;
        always_ff @(posedge clk) begin
            if (rst) sh_q <= '0;
            else     sh_q <= {sh_q[SH_W-2:0], async_i[g]};
        end
        // Edge detected on the synchronised level only.
        assign rise_o[g] = sh_q[SH_W-2] & ~sh_q[SH_W-1];
    end
endmodule

// File: rtl/fcm_gate_timer.sv
module fcm_gate_timer
    import fcm_pkg::*;
#(
    parameter int unsigned REF_KHZ = 1000
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       launch_i,
    input  logic [1:0] code_i,
    output logic       open_o,
    output logic       end_o
);
    localparam int unsigned MAX_TICKS = 64 * REF_KHZ;
    localparam int unsigned TW        = $clog2(MAX_TICKS + 1);

    logic [TW-1:0] tick_q;
    logic [TW-1:0] last_q;
    logic          open_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            open_q <= 1'b0;
            tick_q <= '0;
            last_q <= '0;
        end else if (launch_i) begin
            open_q <= 1'b1;
            tick_q <= '0;
            last_q <= TW'(gate_ms(code_i) * REF_KHZ - 1);
        end else if (open_q) begin
            if (tick_q == last_q) open_q <= 1'b0;
            else                  tick_q <= tick_q + 1'b1;
        end
    end

    assign open_o = open_q;
    assign end_o  = open_q && (tick_q == last_q);
endmodule

// File: rtl/fcm_sat_counter.sv
module fcm_sat_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr_i,
    input  logic         inc_i,
    output logic [W-1:0] cnt_o
);
    localparam logic [W-1:0] TOP = '1;

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst || clr_i)                cnt_q <= '0;
        else if (inc_i && cnt_q != TOP)  cnt_q <= cnt_q + 1'b1;
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/fcm_top.sv
module fcm_top
    import fcm_pkg::*;
#(
    parameter int unsigned REF_KHZ = 1000,
    parameter int unsigned CNT_W   = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       pre_clk_i,
    input  logic       if_clk_i,
    input  logic       cal_clk_i,
    input  logic       wr_en_i,
    input  logic [2:0] addr_i,
    input  logic [7:0] wdata_i,
    output logic [7:0] rdata_o
);
    ctl_t               ctl_q;
    src_e               run_src;
    logic               ctl_wr;
    logic               launch;
    logic               gate_open;
    logic               gate_end;
    logic               done_q;
    logic               sel_rise;
    logic [NUM_SRC-1:0] src_vec;
    logic [NUM_SRC-1:0] rise;
    logic [CNT_W-1:0]   cnt_val;
    logic [CNT_W-1:0]   res_q [NUM_SRC];
    logic [RES_W-1:0]   res16 [NUM_SRC];
    logic               unused_wbits;

    assign unused_wbits = ^{wdata_i[7], wdata_i[3]};
    assign src_vec      = {cal_clk_i, if_clk_i, pre_clk_i};
    assign run_src      = decode_src(ctl_q.sel);

    // Control accepted only while idle.
    assign ctl_wr = wr_en_i && (addr_i == ADDR_CTL) && !ctl_q.start;
    assign launch = ctl_wr && wdata_i[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl_q <= '0;
        end else if (ctl_wr) begin
            ctl_q.sel   <= wdata_i[6:4];
            ctl_q.gate  <= wdata_i[2:1];
            ctl_q.start <= wdata_i[0];
        end else if (done_q) begin
            ctl_q.start <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) done_q <= 1'b0;
        else     done_q <= gate_end;
    end

    fcm_edge_sync #(.N(NUM_SRC), .STAGES(2)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .async_i (src_vec),
        .rise_o  (rise)
    );

    always_comb begin
        case (run_src)
            SRC_PRESC: sel_rise = rise[0];
            SRC_IF:    sel_rise = rise[1];
            SRC_CAL:   sel_rise = rise[2];
            default:   sel_rise = 1'b0;
        endcase
    end

    fcm_gate_timer #(.REF_KHZ(REF_KHZ)) u_gate (
        .clk      (clk),
        .rst      (rst),
        .launch_i (launch),
        .code_i   (wdata_i[2:1]),
        .open_o   (gate_open),
        .end_o    (gate_end)
    );

    fcm_sat_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .clr_i (launch),
        .inc_i (gate_open && sel_rise),
        .cnt_o (cnt_val)
    );

    // Result store, one cycle after the window closes.
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) res_q[i] <= '0;
        end else if (done_q) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (run_src == SRC_NONE)      res_q[i] <= '0;
                else if (run_src == src_e'(i)) res_q[i] <= cnt_val;
            end
        end
    end

    for (genvar g = 0; g < NUM_SRC; g++) begin : g_ext
        assign res16[g] = RES_W'(res_q[g]);
    end

    always_comb begin
        rdata_o = '0;
        if (addr_i == ADDR_CTL) begin
            rdata_o = {1'b0, ctl_q.sel, 1'b0, ctl_q.gate, ctl_q.start};
        end else begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (addr_i[2:1] == 2'(i + 1))
                    rdata_o = addr_i[0] ? res16[i][15:8] : res16[i][7:0];
            end
        end
    end
endmodule

// File: rtl/fcm_checker.sv
module fcm_checker #(
    parameter int unsigned CNT_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [1:0]       gate,
    input logic [2:0]       sel,
    input logic             open,
    input logic             clr,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // R1
    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (!start && cnt == '0));

    // R2
    a_r2_busy_covers_gate: assert property (@(posedge clk) disable iff (rst)
        open |-> start);

    // R3
    a_r3_clear_after_close: assert property (@(posedge clk) disable iff (rst)
        $fell(open) |=> !start);

    // R5
    a_r5_no_count_outside: assert property (@(posedge clk) disable iff (rst)
        (!open && !clr) |=> $stable(cnt));

    // R5
    a_r5_single_step: assert property (@(posedge clk) disable iff (rst)
        !clr |=> (cnt == $past(cnt) || cnt == CNT_W'($past(cnt) + 1'b1)));

    // R6
    a_r6_no_overflow: assert property (@(posedge clk) disable iff (rst)
        (cnt == TOP && !clr) |=> cnt == TOP);

    // R9
    a_r9_cfg_locked: assert property (@(posedge clk) disable iff (rst)
        (start && $past(start)) |-> ($stable(gate) && $stable(sel)));
endmodule

bind fcm_top fcm_checker #(.CNT_W(CNT_W)) u_chk (
    .clk   (clk),
    .rst   (rst),
    .start (ctl_q.start),
    .gate  (ctl_q.gate),
    .sel   (ctl_q.sel),
    .open  (gate_open),
    .clr   (launch),
    .cnt   (cnt_val)
);

// File: tb/sim_fcm_top.sv
`timescale 1ns/1ps
module sim_fcm_top;
    localparam int unsigned REF_KHZ = 200;
    localparam int unsigned CNT_W   = 12;
    localparam int          SATMAX  = (1 << CNT_W) - 1;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [2:0] addr = '0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [2:0] srcs = '0;
    int         hp [3];
    int         scnt [3];
    int         cyc = 0;
    int         checks = 0;
    int         errs = 0;
    int         last [3];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    // Index 0 prescaler, 1 IF, 2 calibration.
    always @(negedge clk) begin
        for (int i = 0; i < 3; i++) begin
            if (scnt[i] >= hp[i] - 1) begin
                scnt[i] = 0;
                srcs[i] = ~srcs[i];
            end else begin
                scnt[i] = scnt[i] + 1;
            end
        end
    end

    fcm_top #(.REF_KHZ(REF_KHZ), .CNT_W(CNT_W)) u0 (
        .clk       (clk),
        .rst       (rst),
        .pre_clk_i (srcs[0]),
        .if_clk_i  (srcs[1]),
        .cal_clk_i (srcs[2]),
        .wr_en_i   (wr_en),
        .addr_i    (addr),
        .wdata_i   (wdata),
        .rdata_o   (rdata)
    );

    function automatic int gcyc(input int code);
        int ms;
        case (code)
            0: ms = 4;
            1: ms = 8;
            2: ms = 32;
            default: ms = 64;
        endcase
        return ms * REF_KHZ;
    endfunction

    function automatic int src_of(input int code);
        case (code)
            1, 7: return 1;
            2, 3: return 0;
            4, 5: return 2;
            default: return -1;
        endcase
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic check_near(input string req, input int act, input int g, input int p);
        int exp;
        exp = g / p;
        if (exp > SATMAX) exp = SATMAX;
        checks++;
        if (act * p < g - p || (act * p > g + p && act != SATMAX) || act > SATMAX) begin
            errs++;
            $display("FAIL %s: actual %0d expected %0d (+/-1)", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [7:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic rd16(input int idx, output int v);
        logic [7:0] lo, hi;
        rd(3'(2 + 2 * idx), lo);
        rd(3'(3 + 2 * idx), hi);
        v = {hi, lo};
    endtask

    task automatic wait_idle(input int t0, output int n);
        logic [7:0] d;
        forever begin
            rd(3'd0, d);
            if (!d[0]) break;
            @(negedge clk);
        end
        n = cyc - t0;
    endtask

    task automatic measure(input int code, input int gate, output int n);
        int t0;
        bus_write(3'd0, {1'b0, 3'(code), 1'b0, 2'(gate), 1'b1});
        t0 = cyc;
        wait_idle(t0, n);
    endtask

    // Checks all three pairs against the model after one measurement.
    task automatic check_pairs(input string req, input int code, input int gate);
        int v, s;
        s = src_of(code);
        for (int i = 0; i < 3; i++) begin
            rd16(i, v);
            if (s < 0)       check({req, " R7 unused clears"}, v, 0);
            else if (i == s) check_near({req, " R4/R5 selected"}, v, gcyc(gate), 2 * hp[i]);
            else             check({req, " R8 others kept"}, v, last[i]);
            last[i] = v;
        end
    endtask

    initial begin
        logic [7:0] d;
        int n, v;
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) begin hp[i] = 3; scnt[i] = 0; last[i] = 0; end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reset read", d, 0);
        end

        // R10 result/spare addresses are not writable
        for (int a = 1; a < 8; a++) bus_write(3'(a), 8'hFF);
        for (int a = 1; a < 8; a++) begin
            rd(3'(a), d);
            check("R10 write ignored", d, 0);
        end

        // R3 window length per gate code, R2 busy and readback
        hp[0] = 2; hp[1] = 3; hp[2] = 5;
        for (int g = 0; g < 4; g++) begin
            measure(1, g, n);
            check("R3 busy cycles", n, gcyc(g) + 1);
            rd(3'd0, d);
            check("R2 ctl readback after done", d, {1'b0, 3'd1, 1'b0, 2'(g), 1'b0});
            check_pairs("R3", 1, g);
        end

        // R4 decode of every used code, R8 isolation
        for (int c = 1; c < 8; c++) begin
            if (c == 6) continue;
            measure(c, 0, n);
            check_pairs("R4", c, 0);
        end

        // R7 unused codes
        measure(0, 0, n);
        check("R7 full window", n, gcyc(0) + 1);
        check_pairs("R7", 0, 0);
        measure(2, 0, n);
        check_pairs("R7 reload", 2, 0);
        measure(6, 1, n);
        check_pairs("R7", 6, 1);

        // R6 saturation and just below it; R11 byte split
        hp[0] = 1;
        measure(2, 2, n);
        rd16(0, v);
        check_near("R6 below limit", v, gcyc(2), 2);
        measure(3, 3, n);
        rd(3'd2, d);
        check("R11 low byte saturated", d, SATMAX & 8'hFF);
        rd(3'd3, d);
        check("R11 high byte saturated", d, SATMAX >> 8);
        rd16(0, v);
        check("R6 saturated count", v, SATMAX);
        last[0] = v;
        rd16(1, last[1]);
        rd16(2, last[2]);

        // R9 control write during a window is ignored
        hp[1] = 4;
        begin
            int t0;
            bus_write(3'd0, {1'b0, 3'd7, 1'b0, 2'd0, 1'b1});
            t0 = cyc;
            repeat (10) @(negedge clk);
            bus_write(3'd0, {1'b0, 3'd4, 1'b0, 2'd3, 1'b1});
            bus_write(3'd0, 8'h00);
            wait_idle(t0, n);
            check("R9 window unchanged", n, gcyc(0) + 1);
            rd(3'd0, d);
            check("R9 ctl unchanged", d, {1'b0, 3'd7, 1'b0, 2'd0, 1'b0});
            check_pairs("R9", 7, 0);
        end

        // Random sources, codes and short gates
        for (int k = 0; k < 8; k++) begin
            int c, g;
            for (int i = 0; i < 3; i++) hp[i] = 1 + int'($urandom_range(7));
            c = int'($urandom_range(7));
            g = int'($urandom_range(1));
            repeat (20) @(negedge clk);
            measure(c, g, n);
            check("R3 random busy", n, gcyc(g) + 1);
            check_pairs("R5 random", c, g);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end

    initial begin
        wait (cyc >= 190000);
        checks++;
        errs++;
        $display("FAIL R2 watchdog: actual %0d cycles expected completion", cyc);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
        $finish;
    end
endmodule